// File: doc/BRIEF.md
# UART Receive Buffer with Status Latch and Flags

This block is the receive-side data buffer of a serial port. The bit-level receiver hands it complete characters, each with four status bits. The block keeps them in order until the bus reads the data register. Every read pops the head entry. The status bits of the popped entry are copied into a separate receive-status register, which software clears by writing to it. The block produces the receive-empty and receive-full flags for the flag register, a receive interrupt request driven by a fill trigger, and a sticky overrun request.

A line-control input selects the buffer depth: the full `DEPTH` when it is high, a single entry when it is low. Any change of that input empties the buffer. A detected line break is stored as an entry that has only the break bit set. When loopback is on, the receiver's characters and breaks are ignored, and characters from the transmitter are stored instead. Each stored entry is 12 bits wide: bits 7:0 hold the character, bit 8 framing error, bit 9 parity error, bit 10 break and bit 11 overrun. The receive-status register holds bits 11:8 of the entry.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the buffer is empty (`rx_empty_o`=1, `rx_full_o`=0), `rx_irq_o`=0, `ovr_irq_o`=0, `rsr_o`=0, and single-entry mode is active.
- R2: While `fifo_en_i` is 1, the buffer holds up to `DEPTH` (16) entries and returns them in push order. `rx_full_o` rises one cycle after the push that brings the count to `DEPTH`.
- R3: While `fifo_en_i` is 0, the depth is 1: `rx_full_o` rises after a single push.
- R4: In a cycle where `fifo_en_i` differs from the mode currently held, the buffer is flushed. Afterwards it is empty and not full, and any push or read in that cycle is discarded.
- R5: A read pulse on `dr_rd_i` pops the head entry. `dr_rdata_o` shows the head entry before the read edge. A read of an empty buffer leaves it empty and not full.
- R6: `rx_irq_o` rises after a push that brings the count to the trigger level (1). It falls after a read that leaves the count at the trigger level minus one. A flush does not change it.
- R7: Each read copies bits 11:8 of the popped entry into `rsr_o`. A pulse on `rsr_wr_i` clears `rsr_o` to 0.
- R8: A pulse on `rx_break_i` (loopback off) pushes the entry 0x400, which has only bit 10 set.
- R9: While `loopback_i` is 1, `rx_push_i` and `rx_break_i` are ignored, and a `tx_push_i` pulse pushes `tx_char_i` with all four status bits 0.
- R10: A push into a full buffer is dropped and sets `ovr_irq_o`. `ovr_irq_o` stays set until a pulse on `ovr_clr_i`.
- R11: When a read and a push arrive in the same cycle, the read is applied first. A full buffer therefore accepts the push and stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | Line-control buffer enable: 1 selects full depth, 0 selects depth 1 |
| loopback_i | input | 1 | Loopback mode select |
| rx_push_i | input | 1 | Receiver has a character to store |
| rx_char_i | input | 8 | Received character |
| rx_stat_i | input | 4 | Received status bits (stored as entry bits 11:8) |
| rx_break_i | input | 1 | Receiver detected a line break |
| tx_push_i | input | 1 | Transmitter sent a character (used in loopback) |
| tx_char_i | input | 8 | Transmitted character |
| dr_rd_i | input | 1 | Bus read of the data register: pops the head entry |
| dr_rdata_o | output | 12 | Head entry |
| rsr_wr_i | input | 1 | Bus write to the receive-status register: clears it |
| rsr_o | output | 4 | Receive-status register |
| ovr_clr_i | input | 1 | Clears the overrun request |
| rx_empty_o | output | 1 | Receive buffer empty flag |
| rx_full_o | output | 1 | Receive buffer full flag |
| rx_irq_o | output | 1 | Receive fill-trigger interrupt request |
| ovr_irq_o | output | 1 | Overrun interrupt request |

## Verification
The bench uses the default parameters: `DEPTH` of 16 and a trigger level of 1. At that depth a full buffer takes only sixteen pushes to reach, so the full flag, the dropped seventeenth push, and a read and push in the same cycle on a full buffer all fit in a short sequence. The run then switches to single-entry mode and back. With a trigger of 1, both the rising edge and the falling edge of the receive request are exercised by ordinary traffic, including a read of an empty buffer just after a flush.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int CHAR_W    = 8;
    localparam int STAT_W    = 4;
    localparam int WORD_W    = CHAR_W + STAT_W;
    localparam int BREAK_BIT = 10;
    typedef logic [WORD_W-1:0] rx_word_t;
    typedef logic [STAT_W-1:0] rx_stat_t;
endpackage

// File: rtl/rxq_src_sel.sv
module rxq_src_sel
    import uart_rx_pkg::*;
(
    input  logic              loopback_i,
    input  logic              rx_push_i,
    input  logic [CHAR_W-1:0] rx_char_i,
    input  rx_stat_t          rx_stat_i,
    input  logic              rx_break_i,
    input  logic              tx_push_i,
    input  logic [CHAR_W-1:0] tx_char_i,
    output logic              push_o,
    output rx_word_t          word_o
);
    always_comb begin
        push_o = 1'b0;
        word_o = '0;
        if (loopback_i) begin
            push_o = tx_push_i;
            word_o = {{STAT_W{1'b0}}, tx_char_i};
        end else if (rx_break_i) begin
            push_o = 1'b1;
            word_o = '0;
            word_o[BREAK_BIT] = 1'b1;
        end else begin
            push_o = rx_push_i;
            word_o = {rx_stat_i, rx_char_i};
        end
    end

    // R9: in loopback, only transmitted characters reach the buffer
    always_comb begin
        if (loopback_i && !tx_push_i) begin
            assert_loop_ignores_rx_R9: assert (!push_o);
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  rx_word_t      wdata_i,
    input  logic [AW-1:0] raddr_i,
    output rx_word_t      rdata_o
);
    rx_word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          rsr_clr_i,
    input  logic          ovr_clr_i,
    input  rx_stat_t      head_stat_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          rx_irq_o,
    output logic          ovr_o,
    output rx_stat_t      rsr_o
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] TRIG_C = CW'(TRIG);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          fen;
        logic          irq;
        logic          ovr;
        rx_stat_t      rsr;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [CW-1:0] eff_depth;
    logic [AW-1:0] idx_mask;
    logic          flush;

    always_comb begin
        st_d      = st_q;
        we_o      = 1'b0;
        waddr_o   = '0;
        eff_depth = st_q.fen ? CW'(DEPTH) : CW'(1);
        idx_mask  = st_q.fen ? AW'(DEPTH - 1) : '0;
        flush     = (fifo_en_i != st_q.fen);
        if (rsr_clr_i) st_d.rsr = '0;
        if (ovr_clr_i) st_d.ovr = 1'b0;
        if (flush) begin
            st_d.fen = fifo_en_i;
            st_d.ptr = '0;
            st_d.cnt = '0;
        end else begin
            if (pop_i) begin
                st_d.rsr = head_stat_i;
                if (st_d.cnt != '0) begin
                    st_d.cnt = st_d.cnt - CW'(1);
                    st_d.ptr = (st_q.ptr + AW'(1)) & idx_mask;
                end
                if (st_d.cnt == TRIG_C - CW'(1)) st_d.irq = 1'b0;
            end
            if (push_i) begin
                if (st_d.cnt == eff_depth) begin
                    st_d.ovr = 1'b1;
                end else begin
                    we_o     = 1'b1;
                    waddr_o  = (st_d.ptr + st_d.cnt[AW-1:0]) & idx_mask;
                    st_d.cnt = st_d.cnt + CW'(1);
                    if (st_d.cnt == TRIG_C) st_d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr_o  = st_q.ptr;
    assign empty_o  = (st_q.cnt == '0);
    assign full_o   = (st_q.cnt == eff_depth);
    assign rx_irq_o = st_q.irq;
    assign ovr_o    = st_q.ovr;
    assign rsr_o    = st_q.rsr;

    assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i != st_q.fen) |=> (empty_o && !full_o));
    assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_single_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.fen |-> st_q.cnt <= CW'(1));
    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o && fifo_en_i == st_q.fen) |=> ovr_o);
    assert_rsr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsr_clr_i && !pop_i) |=> (rsr_o == '0));
    assert_pop_push_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && full_o && fifo_en_i == st_q.fen && !ovr_clr_i)
            |=> (full_o && $stable(ovr_o)));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en_i,
    input  logic              loopback_i,
    input  logic              rx_push_i,
    input  logic [7:0]        rx_char_i,
    input  logic [3:0]        rx_stat_i,
    input  logic              rx_break_i,
    input  logic              tx_push_i,
    input  logic [7:0]        tx_char_i,
    input  logic              dr_rd_i,
    output logic [11:0]       dr_rdata_o,
    input  logic              rsr_wr_i,
    output logic [3:0]        rsr_o,
    input  logic              ovr_clr_i,
    output logic              rx_empty_o,
    output logic              rx_full_o,
    output logic              rx_irq_o,
    output logic              ovr_irq_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          push;
    rx_word_t      push_word;
    rx_word_t      head_word;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    rxq_src_sel u_src (
        .loopback_i (loopback_i),
        .rx_push_i  (rx_push_i),
        .rx_char_i  (rx_char_i),
        .rx_stat_i  (rx_stat_i),
        .rx_break_i (rx_break_i),
        .tx_push_i  (tx_push_i),
        .tx_char_i  (tx_char_i),
        .push_o     (push),
        .word_o     (push_word)
    );

    rxq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (push_word),
        .raddr_i (raddr),
        .rdata_o (head_word)
    );

    rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en_i   (fifo_en_i),
        .push_i      (push),
        .pop_i       (dr_rd_i),
        .rsr_clr_i   (rsr_wr_i),
        .ovr_clr_i   (ovr_clr_i),
        .head_stat_i (head_word[WORD_W-1:CHAR_W]),
        .we_o        (we),
        .waddr_o     (waddr),
        .raddr_o     (raddr),
        .empty_o     (rx_empty_o),
        .full_o      (rx_full_o),
        .rx_irq_o    (rx_irq_o),
        .ovr_o       (ovr_irq_o),
        .rsr_o       (rsr_o)
    );

    assign dr_rdata_o = head_word;

    // R1: flags never claim empty and full together
    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty_o && rx_full_o));
endmodule

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en_i = 1'b0, loopback_i = 1'b0;
    logic        rx_push_i = 1'b0, rx_break_i = 1'b0, tx_push_i = 1'b0;
    logic [7:0]  rx_char_i = '0, tx_char_i = '0;
    logic [3:0]  rx_stat_i = '0;
    logic        dr_rd_i = 1'b0, rsr_wr_i = 1'b0, ovr_clr_i = 1'b0;
    logic [11:0] dr_rdata_o;
    logic [3:0]  rsr_o;
    logic        rx_empty_o, rx_full_o, rx_irq_o, ovr_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [11:0] exp_q[$];
    int m_depth = 1;

    always #4 clk = ~clk;

    uart_rx_fifo u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // driver: pushes from the receiver, updating the expected queue
    task automatic drive_rx(input logic [7:0] c, input logic [3:0] s, input logic brk);
        rx_push_i = !brk; rx_break_i = brk; rx_char_i = c; rx_stat_i = s;
        if (!loopback_i) begin
            if (exp_q.size() < m_depth) exp_q.push_back(brk ? 12'h400 : {s, c});
        end
        @(negedge clk);
        rx_push_i = 1'b0; rx_break_i = 1'b0;
    endtask

    task automatic drive_tx(input logic [7:0] c);
        tx_push_i = 1'b1; tx_char_i = c;
        if (exp_q.size() < m_depth) exp_q.push_back({4'h0, c});
        @(negedge clk);
        tx_push_i = 1'b0;
    endtask

    // monitor: pops one entry and compares against the scoreboard
    task automatic mon_pop(input string tag);
        logic [11:0] e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk({tag, " R5 head word"}, dr_rdata_o, e);
        end else begin
            e = 'x;
        end
        dr_rd_i = 1'b1;
        @(negedge clk);
        dr_rd_i = 1'b0;
        if (!$isunknown(e)) chk({tag, " R7 status latch"}, rsr_o, e[11:8]);
    endtask

    task automatic set_mode(input logic en);
        fifo_en_i = en;
        m_depth = en ? 16 : 1;
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 empty", rx_empty_o, 1);
        chk("R1 full", rx_full_o, 0);
        chk("R1 irq", rx_irq_o, 0);
        chk("R1 ovr", ovr_irq_o, 0);
        chk("R1 rsr", rsr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // single-entry mode
        drive_rx(8'h41, 4'h1, 1'b0);
        chk("R3 full after one", rx_full_o, 1);
        chk("R6 irq raised", rx_irq_o, 1);
        drive_rx(8'h42, 4'h0, 1'b0);
        chk("R10 overrun set", ovr_irq_o, 1);
        mon_pop("R3 pop");
        chk("R6 irq dropped", rx_irq_o, 0);
        chk("R5 empty after pop", rx_empty_o, 1);
        ovr_clr_i = 1'b1; @(negedge clk); ovr_clr_i = 1'b0;
        chk("R10 overrun cleared", ovr_irq_o, 0);

        // flush on enabling full depth
        drive_rx(8'h55, 4'h0, 1'b0);
        set_mode(1'b1);
        chk("R4 flush empty", rx_empty_o, 1);
        chk("R4 flush not full", rx_full_o, 0);
        chk("R6 irq kept by flush", rx_irq_o, 1);
        mon_pop("R5 empty read");
        chk("R5 still empty", rx_empty_o, 1);
        chk("R5 not full", rx_full_o, 0);
        chk("R6 irq dropped on empty read", rx_irq_o, 0);

        // fill to the full depth
        for (int i = 0; i < 16; i++) drive_rx(8'h10 + 8'(i), 4'(i), 1'b0);
        chk("R2 full at 16", rx_full_o, 1);
        chk("R6 irq", rx_irq_o, 1);
        drive_rx(8'hEE, 4'h0, 1'b0);
        chk("R10 drop when full", ovr_irq_o, 1);
        ovr_clr_i = 1'b1; @(negedge clk); ovr_clr_i = 1'b0;

        // read and push together on a full buffer
        chk("R11 head before", dr_rdata_o, exp_q[0]);
        exp_q.pop_front();
        exp_q.push_back({4'hB, 8'h7E});
        dr_rd_i = 1'b1; rx_push_i = 1'b1; rx_char_i = 8'h7E; rx_stat_i = 4'hB;
        @(negedge clk);
        dr_rd_i = 1'b0; rx_push_i = 1'b0;
        chk("R11 still full", rx_full_o, 1);
        chk("R11 no overrun", ovr_irq_o, 0);

        for (int i = 0; i < 16; i++) mon_pop("R2 drain");
        chk("R2 empty after drain", rx_empty_o, 1);
        chk("R7 rsr before clear", rsr_o, 4'hB);
        rsr_wr_i = 1'b1; @(negedge clk); rsr_wr_i = 1'b0;
        chk("R7 rsr cleared", rsr_o, 0);

        // line break
        drive_rx(8'h00, 4'h0, 1'b1);
        chk("R8 break word", dr_rdata_o, 12'h400);
        mon_pop("R8 break pop");

        // loopback
        loopback_i = 1'b1;
        drive_rx(8'h99, 4'h3, 1'b0);
        chk("R9 rx ignored", rx_empty_o, 1);
        drive_rx(8'h00, 4'h0, 1'b1);
        chk("R9 break ignored", rx_empty_o, 1);
        drive_tx(8'hA5);
        chk("R9 tx stored", rx_empty_o, 0);
        mon_pop("R9 loop pop");
        loopback_i = 1'b0;

        // flush on returning to single-entry mode
        for (int i = 0; i < 3; i++) drive_rx(8'h60 + 8'(i), 4'h0, 1'b0);
        set_mode(1'b0);
        chk("R4 flush to single", rx_empty_o, 1);
        drive_rx(8'h31, 4'h2, 1'b0);
        chk("R3 full again", rx_full_o, 1);
        mon_pop("R3 final pop");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule